// File: doc/BRIEF.md
# Glitch-Free Two-Input Clock Switch

This block drives one clock output from either of two clock inputs. The two inputs may run at unrelated frequencies and phases. A select input picks the source, and it may change at any moment. The block never passes a truncated high or low phase to the output.

When the select moves, the active source is released only while it is low. The output then rests low. The newly chosen source takes over at one of its own falling edges, so its first pulse on the output is always complete.

Each input clock has a short shift register that runs on that clock's falling edge. The last stage of the register is the enable for that source. A source may start filling its register only when the other source's register holds no set bit. This interlock keeps the two enables from being set together. An active-high asynchronous reset clears both registers.

Top module: `clk_switch_glitchless`

## Requirements
- R1: While `rst` is high, `clk_out` is low whatever the clocks and the select do.
- R2: `sel` low chooses `clk_a` and `sel` high chooses `clk_b`. After `rst` falls with `sel` low, `clk_out` stays low through the first rising edge of `clk_a`. It follows `clk_a` from the second falling edge of `clk_a` onward (with the default `SYNC_STAGES` = 2).
- R3: The two source enables are never set together. While one source is selected and settled, a high phase of the other source never reaches `clk_out`.
- R4: An enable changes only while its own clock is low. Every transition of `clk_out` outside reset therefore coincides with an edge of `clk_a` or `clk_b`.
- R5: Outside reset, every high and low phase of `clk_out` lasts at least the shorter of the two input half-periods.
- R6: A select pulse that starts after a rising edge of the current source and ends before its next falling edge has no effect on `clk_out`.
- R7: After a switch request, the old source is cut off within two of its own falling edges. The new source does not reach `clk_out` until two of its falling edges have passed after that, so `clk_out` stays low through the new source's next high phase.
- R8: If the select is reversed before a switch completes, the block settles on the latest select value.
- R9: Once a switch has settled, `clk_out` equals the selected input clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Asynchronous active-high reset; clears both enables |
| clk_a | input | 1 | Clock source chosen when `sel` is low |
| clk_b | input | 1 | Clock source chosen when `sel` is high |
| sel | input | 1 | Source choice, asynchronous to both clocks |
| clk_out | output | 1 | Switched clock output |

## Verification
The checks assume that `sel` never changes at the same instant as a falling edge of either clock. A metastable capture in the shift registers would then make the interlock order undefined. The minimum-phase check also assumes that each input keeps a steady half-period, so that the shortest input phase seen so far is a valid lower bound for the output. The stimulus changes `sel` only a few nanoseconds after a clock edge it has just waited for, or after fixed delays that fall off both clock grids. The two clocks have fixed, unrelated half-periods of 10 ns and 17 ns.

// File: rtl/clk_switch_glitchless.sv
`timescale 1ns/1ps
module clk_switch_glitchless #(
  parameter int SYNC_STAGES = 2
) (
  input  logic rst,
  input  logic clk_a,
  input  logic clk_b,
  input  logic sel,
  output logic clk_out
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] pipe_a, pipe_b;
  logic req_a, req_b, en_a, en_b;

  // a source may only start loading once the other side's chain is empty
  assign req_a = ~sel & ~(|pipe_b);
  assign req_b =  sel & ~(|pipe_a);

  always_ff @(negedge clk_a or posedge rst)
    if (rst) pipe_a <= '0;
    else     pipe_a <= {pipe_a[TOP-1:0], req_a};

  always_ff @(negedge clk_b or posedge rst)
    if (rst) pipe_b <= '0;
    else     pipe_b <= {pipe_b[TOP-1:0], req_b};

  assign en_a = pipe_a[TOP];
  assign en_b = pipe_b[TOP];

  assign clk_out = (clk_a & en_a) | (clk_b & en_b);
endmodule

module clk_switch_glitchless_chk (
  input logic rst,
  input logic clk_a,
  input logic clk_b,
  input logic clk_out,
  input logic en_a,
  input logic en_b
);
  real t_a = 0.0, t_b = 0.0, t_o = 0.0, min_in = 1.0e9;
  bit  a_seen = 1'b0, b_seen = 1'b0, o_seen = 1'b0;
  logic last_o = 1'b0;

  AST_ONE_OWNER_A: assert property (@(posedge clk_a) disable iff (rst) !(en_a && en_b)) else $error("both enables set"); // R3
  AST_ONE_OWNER_B: assert property (@(posedge clk_b) disable iff (rst) !(en_a && en_b)) else $error("both enables set"); // R3
  AST_HANDOFF_A: assert property (@(negedge clk_a) disable iff (rst) $rose(en_a) |-> !en_b) else $error("a enabled over b"); // R3
  AST_HANDOFF_B: assert property (@(negedge clk_b) disable iff (rst) $rose(en_b) |-> !en_a) else $error("b enabled over a"); // R3

  always @(en_a)
    if (!rst) AST_EN_A_LOW: assert (!clk_a) else $error("en_a moved while clk_a high"); // R4

  always @(en_b)
    if (!rst) AST_EN_B_LOW: assert (!clk_b) else $error("en_b moved while clk_b high"); // R4

  always @(clk_a) begin
    if (a_seen && ($realtime - t_a) < min_in) min_in = $realtime - t_a;
    t_a = $realtime;
    a_seen = 1'b1;
  end

  always @(clk_b) begin
    if (b_seen && ($realtime - t_b) < min_in) min_in = $realtime - t_b;
    t_b = $realtime;
    b_seen = 1'b1;
  end

  always @(clk_out or rst) begin
    if (rst) begin
      o_seen = 1'b0;
      last_o = clk_out;
    end else if (clk_out !== last_o) begin
      if (o_seen) AST_MIN_PHASE: assert ($realtime - t_o >= min_in) else $error("short output phase"); // R5
      t_o = $realtime;
      o_seen = 1'b1;
      last_o = clk_out;
    end
  end
endmodule

bind clk_switch_glitchless clk_switch_glitchless_chk u_chk (
  .rst(rst), .clk_a(clk_a), .clk_b(clk_b), .clk_out(clk_out), .en_a(en_a), .en_b(en_b)
);

// File: tb/clk_switch_glitchless_test.sv
`timescale 1ns/1ps
module clk_switch_glitchless_test;
  logic rst = 1'b0, clk_a = 1'b0, clk_b = 1'b0, sel = 1'b0;
  logic clk_out;

  int total = 0, bad = 0;
  bit busy = 1'b0;
  int min_ph = 1000000;
  time last_o = 0;
  bit o_seen = 1'b0;

  typedef struct { logic src; string tag; } exp_t;
  exp_t q[$];

  clk_switch_glitchless uut (.rst(rst), .clk_a(clk_a), .clk_b(clk_b), .sel(sel), .clk_out(clk_out));

  initial forever #10 clk_a = ~clk_a;
  initial begin #3; forever #17 clk_b = ~clk_b; end

  task automatic chk(input logic got, input logic exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: clk_out=%b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic expect_src(input logic s, input string tag);
    exp_t e;
    e.src = s;
    e.tag = tag;
    q.push_back(e);
    wait (q.size() == 0);
    wait (!busy);
  endtask

  // R4 / R5: output edges sit on input edges, phases never shorter than 10 ns
  always @(clk_out) begin
    time t;
    t = $time;
    if (rst) o_seen = 1'b0;
    else begin
      total++;
      if (!((t % 10 == 0) || (t >= 3 && (t - 3) % 17 == 0))) begin
        bad++;
        $display("FAIL R4: output edge at %0t, expected on an input edge", t);
      end
      if (o_seen && int'(t - last_o) < min_ph) min_ph = int'(t - last_o);
      last_o = t;
      o_seen = 1'b1;
    end
  end

  // scoreboard monitor
  initial forever begin
    exp_t cur;
    wait (q.size() != 0);
    busy = 1'b1;
    cur = q.pop_front();
    #300;
    for (int k = 0; k < 3; k++) begin
      if (cur.src) @(posedge clk_b); else @(posedge clk_a);
      #1 chk(clk_out, 1'b1, cur.tag);
      if (cur.src) @(negedge clk_b); else @(negedge clk_a);
      #1 chk(clk_out, 1'b0, cur.tag);
    end
    for (int k = 0; k < 2; k++) begin
      if (cur.src) @(posedge clk_a); else @(posedge clk_b);
      #1;
      if ((cur.src ? clk_b : clk_a) == 1'b0) chk(clk_out, 1'b0, "R3");
    end
    busy = 1'b0;
  end

  initial begin
    #20000;
    bad++;
    $display("FAIL R9: watchdog expired, actual=running expected=finished");
    finish_run();
  end

  initial begin
    #1 rst = 1'b1;
    #14 chk(clk_out, 1'b0, "R1");
    #20 chk(clk_out, 1'b0, "R1");
    #20 chk(clk_out, 1'b0, "R1");
    #50 rst = 1'b0;
    #26 chk(clk_out, 1'b0, "R2");
    #20 chk(clk_out, 1'b1, "R2");
    expect_src(1'b0, "R2");

    // R7: a -> b
    @(negedge clk_a); #2 sel = 1'b1;
    @(negedge clk_a); @(negedge clk_a);
    #1 chk(clk_out, 1'b0, "R7");
    @(posedge clk_b); #1 chk(clk_out, 1'b0, "R7");
    expect_src(1'b1, "R9");

    // R7: b -> a
    @(negedge clk_b); #2 sel = 1'b0;
    @(negedge clk_b); @(negedge clk_b);
    #1 chk(clk_out, 1'b0, "R7");
    @(posedge clk_a); #1 chk(clk_out, 1'b0, "R7");
    expect_src(1'b0, "R9");

    // R6: short select pulse inside a high phase of clk_a
    @(posedge clk_a); #2 sel = 1'b1; #5 sel = 1'b0;
    @(posedge clk_a); #1 chk(clk_out, 1'b1, "R6");
    @(negedge clk_a); #1 chk(clk_out, 1'b0, "R6");
    @(posedge clk_a); #1 chk(clk_out, 1'b1, "R6");

    // R8: reversals before completion
    #4 sel = 1'b1; #15 sel = 1'b0;
    expect_src(1'b0, "R8");
    #4 sel = 1'b1; #60 sel = 1'b0; #30 sel = 1'b1;
    expect_src(1'b1, "R8");

    // R6: short select pulse inside a high phase of clk_b
    @(posedge clk_b); #2 sel = 1'b0; #5 sel = 1'b1;
    @(posedge clk_b); #1 chk(clk_out, 1'b1, "R6");
    @(posedge clk_b); #1 chk(clk_out, 1'b1, "R6");

    total++;
    if (min_ph < 10) begin
      bad++;
      $display("FAIL R5: shortest output phase=%0d expected >= 10", min_ph);
    end
    finish_run();
  end
endmodule